// File: doc/BRIEF.md
# Option ROM header scanner

The scanner walks the header of an expansion-card option ROM through a port that returns one byte per access. After a start strobe it rebuilds 16-bit and 24-bit fields from successive byte reads, takes the lowest-addressed byte as least significant, and decides whether the card carries a real ROM at all. A card without one answers every read with the same byte, so its card ID has two equal halves and it has no signature word.

Once the card passes these checks, the scanner reads the flags byte, the section count, the ROM size word and a reserved word. It then steps through the counted list of 16-byte section headers. For each header it validates the zero padding, checks that the section fits inside the declared ROM size, and reports the section's tag, start offset and length with a one-cycle strobe. It latches the first boot section for the boot loader that follows.

Every scan ends with `done_o` raised and an error code. The code is zero on success and nonzero for the first fault found.

Top module: `rom_hdr_scan`

## Requirements
- R1: The block reads one byte per access. `rd_req_o` stays high with a stable `rd_addr_o` until `rd_ack_i` or `rd_err_i` is seen in the same cycle. Multi-byte fields are little-endian, with the lower address holding the less significant byte.
- R2: Bytes 0 and 1 form the card ID, reported on `card_id_o`. If its high and low bytes are equal, the scan ends with error code 2 and no further reads are made.
- R3: The word at byte 2 must equal 16'hAAFF. Any other value ends the scan with error code 3.
- R4: Byte 4 holds the flags. `boot_flag_o` is 1 exactly when that byte equals 8'h04.
- R5: Byte 5 holds the section count, reported on `sec_count_o`. A count of zero ends the scan with error code 5.
- R6: The word at byte 6 is the ROM size in units of 256 bytes, reported on `rom_size_o`. The word at byte 8 must be zero, otherwise the scan ends with error code 4.
- R7: Section header n starts at byte 10 + 16·n. Its layout is:
  - a tag word at +0;
  - four words at +2..+9 that must be zero;
  - a 24-bit start offset at +10;
  - a 16-bit length at +13;
  - a byte at +15 that must be zero.

  A nonzero pad word or a nonzero final byte ends the scan with error code 6.
- R8: Each accepted section is reported for one cycle through `sec_valid_o`, together with its index, tag, offset and length. `sec_boot_o` is 1 exactly when the tag is 16'h4226 ("&B"). Any other tag, including 16'h4426 ("&D"), is reported with `sec_boot_o` at 0.
- R9: A section whose offset plus length exceeds the size word times 256 is not reported, and the scan ends with error code 7. A section that ends exactly at the limit is accepted.
- R10: A bus error on any byte read ends the scan at once with error code 1, and no further reads are made.
- R11: After the last section has been accepted, `done_o` rises with error code 0. `boot_off_o` and `boot_len_o` hold the first "&B" section. `no_boot_o` is 1 when the scan succeeded but found no "&B" section.
- R12: `start_i` is ignored while `busy_o` is high. A start taken while idle or done clears `done_o`, the ID, count, size and boot results, and restarts the walk at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a scan |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | ADDR_W | Byte address |
| rd_ack_i | input | 1 | Read data valid this cycle |
| rd_data_i | input | 8 | Read data |
| rd_err_i | input | 1 | Bus error on the current read |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan finished (held until the next start) |
| err_code_o | output | 3 | 0 ok, 1 bus, 2 no ROM, 3 signature, 4 reserved, 5 no sections, 6 padding, 7 range |
| card_id_o | output | 16 | Card ID word |
| boot_flag_o | output | 1 | Flags byte marks the ROM bootable |
| sec_count_o | output | CNT_W | Section count |
| rom_size_o | output | 16 | ROM size in 256-byte units |
| sec_valid_o | output | 1 | Section report strobe |
| sec_idx_o | output | CNT_W | Index of the reported section |
| sec_tag_o | output | 16 | Section tag word |
| sec_off_o | output | 24 | Section start offset |
| sec_len_o | output | 16 | Section length |
| sec_boot_o | output | 1 | Reported section is a boot section |
| boot_found_o | output | 1 | A boot section has been latched |
| boot_off_o | output | 24 | Offset of the first boot section |
| boot_len_o | output | 16 | Length of the first boot section |
| no_boot_o | output | 1 | Successful scan with no boot section |

## Verification
The bench goes after the following corner cases, each run under several read latencies:
- A card that returns one constant byte: a design that compared the wrong bytes would go on reading a card that has no ROM.
- A section that ends exactly at the ROM limit, next to one that ends a byte past it: an off-by-one comparator would reject the first or accept the second.
- A 24-bit offset whose top byte is nonzero: a scanner that assembled only two bytes, or used the wrong byte order, would report a different offset.
- Two boot sections: a latch that was not guarded would keep the second one.
- Bus errors inside a section header and on the very first byte: a design that did not stop at once would issue reads the reference does not expect.
- A second start during a scan: if it restarted the walk, byte 0 would be requested out of order.

// File: rtl/rom_scan_pkg.sv
package rom_scan_pkg;
  localparam logic [15:0] SIG_WORD  = 16'hAAFF;
  localparam logic [15:0] TAG_BOOT  = 16'h4226;
  localparam logic [7:0]  FLAG_BOOT = 8'h04;
  localparam int unsigned HDR_BASE  = 10;
  localparam int unsigned HDR_STEP  = 16;

  typedef enum logic [2:0] {
    ERR_NONE, ERR_BUS, ERR_NOROM, ERR_SIG, ERR_RSV, ERR_NOSEC, ERR_PAD, ERR_RANGE
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ID, S_SIG, S_FLG, S_CNT, S_SIZE, S_RSV,
    S_TAG, S_PAD, S_OFF, S_LEN, S_MBZ, S_EMIT, S_DONE
  } st_e;
endpackage

// File: rtl/rom_byte_fetch.sv
module rom_byte_fetch #(
  parameter int ADDR_W = 16,
  parameter int MAXB   = 3,
  localparam int CW    = $clog2(MAXB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CW-1:0]     nbytes_i,
  output logic              done_o,
  output logic              err_o,
  output logic [8*MAXB-1:0] value_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [7:0]        rd_data_i,
  input  logic              rd_err_i
);
  logic              active_q, done_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     left_q, idx_q;
  logic [8*MAXB-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      addr_q <= '0; left_q <= '0; idx_q <= '0; val_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        addr_q   <= addr_i;
        left_q   <= nbytes_i;
        idx_q    <= '0;
        val_q    <= '0;
      end else if (active_q) begin
        if (rd_err_i) begin
          active_q <= 1'b0;
          err_q    <= 1'b1;
        end else if (rd_ack_i) begin
          val_q[{idx_q, 3'b000} +: 8] <= rd_data_i;  // little-endian assembly
          idx_q  <= idx_q + 1'b1;
          addr_q <= addr_q + 1'b1;
          left_q <= left_q - 1'b1;
          if (left_q == CW'(1)) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign rd_req_o  = active_q;
  assign rd_addr_o = addr_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign value_o   = val_q;

  p_req_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i && !rd_err_i) |=> (rd_req_o && $stable(rd_addr_o)))
    else $error("request dropped or address moved before response");
endmodule

// File: rtl/rom_range_chk.sv
module rom_range_chk #(
  parameter int OFF_W  = 24,
  parameter int LEN_W  = 16,
  parameter int SIZE_W = 16,
  localparam int W     = ((OFF_W > SIZE_W + 8) ? OFF_W : SIZE_W + 8) + 2
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              over_o
);
  logic [W-1:0] end_w, lim_w;
  assign end_w  = W'(off_i) + W'(len_i);
  assign lim_w  = W'({size_i, 8'h00});
  assign over_o = end_w > lim_w;
endmodule

// File: rtl/rom_hdr_scan.sv
module rom_hdr_scan
  import rom_scan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [7:0]        rd_data_i,
  input  logic              rd_err_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        err_code_o,
  output logic [15:0]       card_id_o,
  output logic              boot_flag_o,
  output logic [CNT_W-1:0]  sec_count_o,
  output logic [15:0]       rom_size_o,
  output logic              sec_valid_o,
  output logic [CNT_W-1:0]  sec_idx_o,
  output logic [15:0]       sec_tag_o,
  output logic [23:0]       sec_off_o,
  output logic [15:0]       sec_len_o,
  output logic              sec_boot_o,
  output logic              boot_found_o,
  output logic [23:0]       boot_off_o,
  output logic [15:0]       boot_len_o,
  output logic              no_boot_o
);
  localparam int MAXB = 3;
  localparam int NW   = $clog2(MAXB + 1);

  st_e               state_q;
  err_e              err_q;
  logic              pend_q, done_q, flag_q, sec_valid_q, sec_boot_q, boot_found_q;
  logic [ADDR_W-1:0] base_q, f_addr;
  logic [CNT_W-1:0]  cnt_q, left_q, idx_q, sec_idx_q;
  logic [1:0]        pad_q;
  logic [15:0]       id_q, size_q, tag_q, len_q, sec_tag_q, sec_len_q, boot_len_q;
  logic [23:0]       off_q, sec_off_q, boot_off_q;
  logic [NW-1:0]     f_n;
  logic              is_fetch, f_start, f_done, f_err, over;
  logic [8*MAXB-1:0] f_val;
  logic [15:0]       w;
  logic [7:0]        b;
  logic              busy;

  assign busy = (state_q != S_IDLE) && (state_q != S_DONE);
  assign w    = f_val[15:0];
  assign b    = f_val[7:0];

  always_comb begin
    is_fetch = 1'b1;
    f_addr   = '0;
    f_n      = NW'(2);
    case (state_q)
      S_ID:   f_addr = ADDR_W'(0);
      S_SIG:  f_addr = ADDR_W'(2);
      S_FLG:  begin f_addr = ADDR_W'(4); f_n = NW'(1); end
      S_CNT:  begin f_addr = ADDR_W'(5); f_n = NW'(1); end
      S_SIZE: f_addr = ADDR_W'(6);
      S_RSV:  f_addr = ADDR_W'(8);
      S_TAG:  f_addr = base_q;
      S_PAD:  f_addr = base_q + ADDR_W'(2) + ADDR_W'({pad_q, 1'b0});
      S_OFF:  begin f_addr = base_q + ADDR_W'(10); f_n = NW'(3); end
      S_LEN:  f_addr = base_q + ADDR_W'(13);
      S_MBZ:  begin f_addr = base_q + ADDR_W'(15); f_n = NW'(1); end
      default: is_fetch = 1'b0;
    endcase
  end
  assign f_start = is_fetch && !pend_q;

  rom_byte_fetch #(.ADDR_W(ADDR_W), .MAXB(MAXB)) u_fetch (
    .clk_i, .rst_ni,
    .start_i(f_start), .addr_i(f_addr), .nbytes_i(f_n),
    .done_o(f_done), .err_o(f_err), .value_o(f_val),
    .rd_req_o, .rd_addr_o, .rd_ack_i, .rd_data_i, .rd_err_i
  );

  rom_range_chk #(.OFF_W(24), .LEN_W(16), .SIZE_W(16)) u_range (
    .off_i(off_q), .len_i(len_q), .size_i(size_q), .over_o(over)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; err_q <= ERR_NONE; pend_q <= 1'b0; done_q <= 1'b0;
      flag_q <= 1'b0; sec_valid_q <= 1'b0; sec_boot_q <= 1'b0; boot_found_q <= 1'b0;
      base_q <= '0; cnt_q <= '0; left_q <= '0; idx_q <= '0; sec_idx_q <= '0; pad_q <= '0;
      id_q <= '0; size_q <= '0; tag_q <= '0; len_q <= '0; off_q <= '0;
      sec_tag_q <= '0; sec_len_q <= '0; sec_off_q <= '0; boot_off_q <= '0; boot_len_q <= '0;
    end else begin
      sec_valid_q <= 1'b0;
      if (start_i && !busy) begin
        state_q <= S_ID; err_q <= ERR_NONE; pend_q <= 1'b0; done_q <= 1'b0;
        flag_q <= 1'b0; boot_found_q <= 1'b0; boot_off_q <= '0; boot_len_q <= '0;
        id_q <= '0; size_q <= '0; cnt_q <= '0; idx_q <= '0;
        base_q <= ADDR_W'(HDR_BASE);
      end else if (is_fetch) begin
        if (!pend_q) begin
          pend_q <= 1'b1;
        end else if (f_err) begin
          pend_q <= 1'b0; state_q <= S_DONE; done_q <= 1'b1; err_q <= ERR_BUS;
        end else if (f_done) begin
          pend_q <= 1'b0;
          case (state_q)
            S_ID: begin
              id_q <= w;
              if (w[15:8] == w[7:0]) begin
                state_q <= S_DONE; done_q <= 1'b1; err_q <= ERR_NOROM;
              end else state_q <= S_SIG;
            end
            S_SIG:
              if (w != SIG_WORD) begin
                state_q <= S_DONE; done_q <= 1'b1; err_q <= ERR_SIG;
              end else state_q <= S_FLG;
            S_FLG: begin
              flag_q  <= (b == FLAG_BOOT);
              state_q <= S_CNT;
            end
            S_CNT: begin
              cnt_q  <= CNT_W'(b);
              left_q <= CNT_W'(b);
              if (b == 8'h00) begin
                state_q <= S_DONE; done_q <= 1'b1; err_q <= ERR_NOSEC;
              end else state_q <= S_SIZE;
            end
            S_SIZE: begin
              size_q  <= w;
              state_q <= S_RSV;
            end
            S_RSV:
              if (w != 16'h0) begin
                state_q <= S_DONE; done_q <= 1'b1; err_q <= ERR_RSV;
              end else state_q <= S_TAG;
            S_TAG: begin
              tag_q   <= w;
              pad_q   <= '0;
              state_q <= S_PAD;
            end
            S_PAD:
              if (w != 16'h0) begin
                state_q <= S_DONE; done_q <= 1'b1; err_q <= ERR_PAD;
              end else if (pad_q == 2'd3) state_q <= S_OFF;
              else pad_q <= pad_q + 1'b1;
            S_OFF: begin
              off_q   <= f_val[23:0];
              state_q <= S_LEN;
            end
            S_LEN: begin
              len_q   <= w;
              state_q <= S_MBZ;
            end
            S_MBZ:
              if (b != 8'h00) begin
                state_q <= S_DONE; done_q <= 1'b1; err_q <= ERR_PAD;
              end else state_q <= S_EMIT;
            default: state_q <= S_DONE;
          endcase
        end
      end else if (state_q == S_EMIT) begin
        if (over) begin
          state_q <= S_DONE; done_q <= 1'b1; err_q <= ERR_RANGE;
        end else begin
          sec_valid_q <= 1'b1;
          sec_idx_q   <= idx_q;
          sec_tag_q   <= tag_q;
          sec_off_q   <= off_q;
          sec_len_q   <= len_q;
          sec_boot_q  <= (tag_q == TAG_BOOT);
          if ((tag_q == TAG_BOOT) && !boot_found_q) begin
            boot_found_q <= 1'b1;
            boot_off_q   <= off_q;
            boot_len_q   <= len_q;
          end
          idx_q  <= idx_q + 1'b1;
          base_q <= base_q + ADDR_W'(HDR_STEP);
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            state_q <= S_DONE; done_q <= 1'b1; err_q <= ERR_NONE;
          end else state_q <= S_TAG;
        end
      end
    end
  end

  assign busy_o       = busy;
  assign done_o       = done_q;
  assign err_code_o   = err_q;
  assign card_id_o    = id_q;
  assign boot_flag_o  = flag_q;
  assign sec_count_o  = cnt_q;
  assign rom_size_o   = size_q;
  assign sec_valid_o  = sec_valid_q;
  assign sec_idx_o    = sec_idx_q;
  assign sec_tag_o    = sec_tag_q;
  assign sec_off_o    = sec_off_q;
  assign sec_len_o    = sec_len_q;
  assign sec_boot_o   = sec_boot_q;
  assign boot_found_o = boot_found_q;
  assign boot_off_o   = boot_off_q;
  assign boot_len_o   = boot_len_q;
  assign no_boot_o    = done_q && (err_q == ERR_NONE) && !boot_found_q;

  p_abort_bus_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_err |=> (done_q && err_q == ERR_BUS))
    else $error("bus error did not end the scan");

  p_norom_id_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && err_q == ERR_NOROM) |-> (id_q[15:8] == id_q[7:0]))
    else $error("no-ROM reported for an ID with distinct bytes");

  p_sec_fit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_valid_q |-> ((25'(sec_off_q) + 25'(sec_len_q)) <= {1'b0, size_q, 8'h00}))
    else $error("reported section overruns the ROM");

  p_boot_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(boot_found_q) |-> (sec_valid_q && sec_boot_q && boot_off_q == sec_off_q))
    else $error("boot latch not tied to a boot section report");

  p_done_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy && !rd_req_o))
    else $error("done while still scanning");
endmodule

// File: tb/tb_rom_hdr_scan.sv
`timescale 1ns/1ps
module tb_rom_hdr_scan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rd_req, rd_ack, rd_err, busy, done, sec_valid, sec_boot, boot_found, no_boot, boot_flag;
  logic [15:0] rd_addr, card_id, rom_size, sec_tag, sec_len, boot_len;
  logic [7:0]  rd_data, sec_count, sec_idx;
  logic [2:0]  err_code;
  logic [23:0] sec_off, boot_off;

  always #2 clk = ~clk;  // 250 MHz

  rom_hdr_scan dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data), .rd_err_i(rd_err),
    .busy_o(busy), .done_o(done), .err_code_o(err_code), .card_id_o(card_id),
    .boot_flag_o(boot_flag), .sec_count_o(sec_count), .rom_size_o(rom_size),
    .sec_valid_o(sec_valid), .sec_idx_o(sec_idx), .sec_tag_o(sec_tag), .sec_off_o(sec_off),
    .sec_len_o(sec_len), .sec_boot_o(sec_boot), .boot_found_o(boot_found),
    .boot_off_o(boot_off), .boot_len_o(boot_len), .no_boot_o(no_boot)
  );

  logic [7:0] mem [0:4095];
  int lat = 0, err_at = -1, wcnt = 0;
  int n_cmp = 0, n_bad = 0;
  int exp_addr[$];
  logic [71:0] exp_sec[$];
  int e_code, e_id, e_size, e_cnt, e_boff, e_blen;
  bit e_flag, e_found;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // responder + per-clock comparison of read addresses and section reports
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_ack = 1'b0; rd_err = 1'b0; rd_data = 8'h00; wcnt = 0;
    end else begin
      if (sec_valid) begin
        if (exp_sec.size() == 0) chk(1'b0, "R8", "unexpected section", {sec_idx, sec_tag}, 0);
        else begin
          logic [71:0] es;
          es = exp_sec.pop_front();
          chk({sec_idx, sec_tag, sec_off, sec_len, sec_boot} == {es[70:63], es[62:47], es[46:23], es[22:7], es[0]},
              "R8", "section report", {sec_idx, sec_tag, sec_off, sec_len, sec_boot},
              {es[70:63], es[62:47], es[46:23], es[22:7], es[0]});
        end
      end
      rd_ack = 1'b0; rd_err = 1'b0;
      if (rd_req) begin
        if (wcnt >= lat) begin
          wcnt = 0;
          if (exp_addr.size() == 0) chk(1'b0, "R10", "unexpected read", rd_addr, -1);
          else begin
            int ea;
            ea = exp_addr.pop_front();
            chk(int'(rd_addr) == ea, "R1", "read address", rd_addr, ea);
          end
          if (int'(rd_addr) == err_at) rd_err = 1'b1;
          else begin rd_ack = 1'b1; rd_data = mem[rd_addr[11:0]]; end
        end else wcnt++;
      end else wcnt = 0;
    end
  end

  // ---------------- behavioural reference ----------------
  task automatic rdn(input int a, input int n, output int v, inout bit be);
    v = 0;
    for (int i = 0; i < n; i++) begin
      if (be) return;
      exp_addr.push_back(a + i);
      if (a + i == err_at) begin be = 1; return; end
      v = v | (int'(mem[a + i]) << (8 * i));
    end
  endtask

  task automatic model();
    bit be = 0;
    int v, fl, tag, off, len;
    e_code = 0; e_id = 0; e_size = 0; e_cnt = 0; e_flag = 0; e_found = 0; e_boff = 0; e_blen = 0;
    rdn(0, 2, v, be); if (be) begin e_code = 1; return; end
    e_id = v;
    if (v[15:8] == v[7:0]) begin e_code = 2; return; end
    rdn(2, 2, v, be); if (be) begin e_code = 1; return; end
    if (v != 'hAAFF) begin e_code = 3; return; end
    rdn(4, 1, fl, be); if (be) begin e_code = 1; return; end
    e_flag = (fl == 4);
    rdn(5, 1, v, be); if (be) begin e_code = 1; return; end
    e_cnt = v;
    if (v == 0) begin e_code = 5; return; end
    rdn(6, 2, v, be); if (be) begin e_code = 1; return; end
    e_size = v;
    rdn(8, 2, v, be); if (be) begin e_code = 1; return; end
    if (v != 0) begin e_code = 4; return; end
    for (int s = 0; s < e_cnt; s++) begin
      int bs;
      bs = 10 + 16 * s;
      rdn(bs, 2, tag, be); if (be) begin e_code = 1; return; end
      for (int k = 0; k < 4; k++) begin
        rdn(bs + 2 + 2 * k, 2, v, be); if (be) begin e_code = 1; return; end
        if (v != 0) begin e_code = 6; return; end
      end
      rdn(bs + 10, 3, off, be); if (be) begin e_code = 1; return; end
      rdn(bs + 13, 2, len, be); if (be) begin e_code = 1; return; end
      rdn(bs + 15, 1, v, be); if (be) begin e_code = 1; return; end
      if (v != 0) begin e_code = 6; return; end
      if (longint'(off) + len > longint'(e_size) * 256) begin e_code = 7; return; end
      exp_sec.push_back({1'b0, 8'(s), 16'(tag), 24'(off), 16'(len), 6'b0, tag == 'h4226});
      if (tag == 'h4226 && !e_found) begin e_found = 1; e_boff = off; e_blen = len; end
    end
  endtask

  // ---------------- image builders ----------------
  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < 4096; i++) mem[i] = v;
  endtask
  task automatic put(input int a, input int n, input int v);
    for (int i = 0; i < n; i++) mem[a + i] = 8'(v >> (8 * i));
  endtask
  task automatic hdr(input int id, input int sg, input int fl, input int cnt, input int sz, input int rsv);
    fill(8'h00);
    put(0, 2, id); put(2, 2, sg); put(4, 1, fl); put(5, 1, cnt); put(6, 2, sz); put(8, 2, rsv);
  endtask
  task automatic sec(input int s, input int tag, input int off, input int len, input int padv, input int mbz);
    int bs;
    bs = 10 + 16 * s;
    put(bs, 2, tag); put(bs + 4, 2, padv); put(bs + 10, 3, off); put(bs + 13, 2, len); put(bs + 15, 1, mbz);
  endtask

  task automatic scan(input string name, input int latency, input int eat, input int restart_at);
    int t = 0;
    lat = latency; err_at = eat;
    exp_addr.delete(); exp_sec.delete();
    model();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (restart_at > 0) begin
      repeat (restart_at) @(negedge clk);
      chk(busy == 1'b1, "R12", {name, " busy before second start"}, busy, 1);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!done && t < 20000) begin @(negedge clk); t++; end
    @(negedge clk);
    chk(done == 1'b1, "R11", {name, " done"}, done, 1);
    chk(int'(err_code) == e_code, "R10", {name, " error code"}, err_code, e_code);
    chk(int'(card_id) == e_id, "R2", {name, " card id"}, card_id, e_id);
    chk(boot_flag == e_flag, "R4", {name, " boot flag"}, boot_flag, e_flag);
    chk(int'(sec_count) == e_cnt, "R5", {name, " section count"}, sec_count, e_cnt);
    chk(int'(rom_size) == e_size, "R6", {name, " rom size"}, rom_size, e_size);
    chk(boot_found == e_found && int'(boot_off) == e_boff && int'(boot_len) == e_blen, "R11",
        {name, " boot latch"}, {boot_found, boot_off, boot_len}, {e_found, 24'(e_boff), 16'(e_blen)});
    chk(no_boot == (e_code == 0 && !e_found), "R11", {name, " no boot"}, no_boot, (e_code == 0 && !e_found));
    chk(exp_addr.size() == 0, "R1", {name, " reads left over"}, exp_addr.size(), 0);
    chk(exp_sec.size() == 0, "R8", {name, " sections left over"}, exp_sec.size(), 0);
    chk(rd_req == 1'b0 && busy == 1'b0, "R12", {name, " idle after done"}, {rd_req, busy}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({done, busy, rd_req, sec_valid, err_code} == 7'b0, "R12", "reset state", {done, busy, rd_req, sec_valid, err_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R8 R11: diagnostic + boot sections, two latencies
    hdr('h0022, 'hAAFF, 4, 2, 'h20, 0);
    sec(0, 'h4426, 42, 5152, 0, 0);
    sec(1, 'h4226, 5194, 2018, 0, 0);
    scan("r11_basic", 0, -1, 0);
    scan("r1_latency", 3, -1, 0);
    // R2: single-register card
    fill(8'h04);
    scan("r2_norom", 1, -1, 0);
    // R3: bad signature
    hdr('h0022, 'h1234, 4, 1, 'h20, 0);
    scan("r3_sig", 0, -1, 0);
    // R4 R11: not bootable, diagnostic only
    hdr('h0122, 'hAAFF, 0, 1, 'h20, 0);
    sec(0, 'h4426, 42, 100, 0, 0);
    scan("r4_noboot", 2, -1, 0);
    // R5: zero sections
    hdr('h0022, 'hAAFF, 4, 0, 'h20, 0);
    scan("r5_zero", 0, -1, 0);
    // R6: reserved word nonzero
    hdr('h0022, 'hAAFF, 4, 1, 'h20, 'h0100);
    sec(0, 'h4226, 42, 100, 0, 0);
    scan("r6_rsv", 1, -1, 0);
    // R7: pad word nonzero, then trailing byte nonzero
    hdr('h0022, 'hAAFF, 4, 2, 'h20, 0);
    sec(0, 'h4426, 42, 100, 0, 0);
    sec(1, 'h4226, 200, 100, 'h0001, 0);
    scan("r7_pad", 0, -1, 0);
    sec(1, 'h4226, 200, 100, 0, 'h80);
    scan("r7_mbz", 1, -1, 0);
    // R9: exact fit accepted, one byte over rejected
    hdr('h0022, 'hAAFF, 4, 2, 1, 0);
    sec(0, 'h4226, 200, 56, 0, 0);
    sec(1, 'h4426, 200, 57, 0, 0);
    scan("r9_range", 0, -1, 0);
    // R10: bus error inside a header, and on byte 0
    hdr('h0022, 'hAAFF, 4, 2, 'h20, 0);
    sec(0, 'h4426, 42, 100, 0, 0);
    sec(1, 'h4226, 200, 100, 0, 0);
    scan("r10_buserr_hdr", 1, 23, 0);
    scan("r10_buserr_first", 0, 0, 0);
    // R1 R8 R11: 24-bit offset, unknown tag, second boot section ignored
    hdr('h3322, 'hAAFF, 4, 4, 'hFFFF, 0);
    sec(0, 'h4426, 42, 100, 0, 0);
    sec(1, 'h4226, 'h123456, 'h0100, 0, 0);
    sec(2, 'h5026, 'h20000, 'h10, 0, 0);
    sec(3, 'h4226, 'h300000, 'h0200, 0, 0);
    scan("r8_multi", 2, -1, 0);
    // R12: second start while busy is ignored
    scan("r12_restart", 1, -1, 6);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule